// File: doc/BRIEF.md
# Packed Sub-Word Min/Max Execution Unit

This unit executes one integer "video" instruction per cycle: it selects a byte, a halfword or the whole word from each of two source values, widens each to 32 bits with zero or sign extension, and keeps the larger or the smaller of the two. The comparison uses the true numeric value, so it stays correct when one operand is signed and the other is not. The second operand can come from a register or from a 20-bit immediate in the instruction word.

After the selection, an optional clamp adapts the result to the signedness of the destination. A post stage then combines the result with a third value C. It can add C, take a second min or max against C, place the result into one byte or halfword lane of C, or pass the result through unchanged. The 32-bit result and a valid flag are registered one clock after the input strobe.

Top module: `vid_minmax_unit`

## Requirements
- R1: An operand's 2-bit type code selects its width: 2 selects a halfword, 3 selects a full word, and 0 or 1 select a byte. The A type code is insn[38:37] and the B type code is insn[30:29].
- R2: The lane selector is insn[37:36] for A and insn[29:28] for B. A byte operand is taken from bits [8*sel+7 : 8*sel]. A halfword operand uses only sel[0] and is taken from bits [16*sel0+15 : 16*sel0]. A word operand ignores the selector. The operand is sign-extended when it is signed (insn[48] for A, insn[49] for a register B) and zero-extended otherwise.
- R3: When insn[50] is 0, B is the immediate insn[35:16]. It is sign-extended from its bit 19 when insn[49] is 1 and zero-extended when insn[49] is 0.
- R4: insn[56]=1 keeps the larger operand and insn[56]=0 keeps the smaller one. When A and B have the same signedness, the comparison uses that signedness.
- R5: When A and B have different signedness, the true mathematical value decides the comparison. A max result then counts as unsigned and a min result as signed.
- R6: When insn[55] is 1, the result is clamped. A signed destination (insn[54]=1) with an unsigned result is clamped to at most 0x7FFFFFFF. An unsigned destination with a signed result is clamped to at least 0.
- R7: The post code insn[53:51] merges the low bits of the result into C as follows, and C's other bits pass through:
  - 0: the low 16 bits go to C[31:16].
  - 1: the low 16 bits go to C[15:0].
  - 2: the low 8 bits go to C[7:0].
  - 3: the low 8 bits go to C[23:16].
- R8: Post code 4 outputs the result plus C, modulo 2^32, with no saturation.
- R9: Post code 5 outputs the minimum and post code 6 the maximum of the result and C. Both compare as signed when insn[54]=1 and as unsigned otherwise.
- R10: Post code 7 outputs the result unchanged.
- R11: out_valid and out_result are updated one clock after in_valid. A synchronous active-high reset clears out_valid. out_result holds its value in any cycle without in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 64 | Instruction word |
| opa | input | 32 | Source value A |
| opb | input | 32 | Source value B (ignored in immediate form) |
| opc | input | 32 | Third value C for the post stage |
| out_valid | output | 1 | Result is valid |
| out_result | output | 32 | Registered result |

## Verification
The assertions are checked on every cycle and cover the following:
- the one-cycle valid timing and the hold of the result when no instruction is present;
- the lanes of C that the merge codes must preserve;
- the bounds that the post min and max place against C;
- the sign bit of a clamped pass-through result.

Some behaviour can only be shown by the bench's directed and random scenarios against its reference function. This covers:
- the numeric value of the selected, extended lane;
- the choice of winner when signedness is mixed;
- the sign extension of the immediate;
- the exact clamp values;
- the wrap of the accumulate.

// File: rtl/vid_minmax_unit.sv
module vid_minmax_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [63:0] insn,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  input  logic [31:0] opc,
  output logic        out_valid,
  output logic [31:0] out_result
);

  function automatic logic [31:0] pick_lane(input logic [31:0] r, input logic [1:0] tc,
                                            input logic [1:0] sel, input logic sg);
    logic [31:0] s;
    case (tc)
      2'd3: pick_lane = r;
      2'd2: begin
        s = r >> {sel[0], 4'b0000};
        pick_lane = {{16{sg & s[15]}}, s[15:0]};
      end
      default: begin
        s = r >> {sel, 3'b000};
        pick_lane = {{24{sg & s[7]}}, s[7:0]};
      end
    endcase
  endfunction

  logic a_sg, b_sg, b_reg, is_max, sat, dst_sg, res_sg, a_lt_b, r_lt_c;
  logic [2:0]  post;
  logic [31:0] a_val, b_val, pick, clamped, result;
  logic        unused_bits;

  assign a_sg   = insn[48];
  assign b_sg   = insn[49];
  assign b_reg  = insn[50];
  assign is_max = insn[56];
  assign sat    = insn[55];
  assign dst_sg = insn[54];
  assign post   = insn[53:51];
  assign unused_bits = ^{insn[63:57], insn[47:39], insn[15:0]};

  assign a_val = pick_lane(opa, insn[38:37], insn[37:36], a_sg);
  assign b_val = b_reg ? pick_lane(opb, insn[30:29], insn[29:28], b_sg)
                       : {{12{b_sg & insn[35]}}, insn[35:16]};

  assign a_lt_b = $signed({a_sg & a_val[31], a_val}) < $signed({b_sg & b_val[31], b_val});
  assign pick   = (is_max ^ a_lt_b) ? a_val : b_val;
  assign res_sg = (a_sg == b_sg) ? a_sg : !is_max;

  always_comb begin
    clamped = pick;
    if (sat && dst_sg && !res_sg && pick[31]) clamped = 32'h7FFF_FFFF;
    if (sat && !dst_sg && res_sg && pick[31]) clamped = 32'h0;
  end

  assign r_lt_c = dst_sg ? ($signed(clamped) < $signed(opc)) : (clamped < opc);

  always_comb begin
    case (post)
      3'd0: result = {clamped[15:0], opc[15:0]};
      3'd1: result = {opc[31:16], clamped[15:0]};
      3'd2: result = {opc[31:8], clamped[7:0]};
      3'd3: result = {opc[31:24], clamped[7:0], opc[15:0]};
      3'd4: result = clamped + opc;
      3'd5: result = r_lt_c ? clamped : opc;
      3'd6: result = r_lt_c ? opc : clamped;
      default: result = clamped;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
    if (in_valid) out_result <= result;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (in_valid |=> out_valid)); // R11
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) (!in_valid |=> !out_valid)); // R11
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst) (!in_valid |=> $stable(out_result))); // R11
  AST_MERGE_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && post == 3'd0 |=> out_result[15:0] == $past(opc[15:0]))); // R7
  AST_MERGE_B0_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && post == 3'd2 |=> out_result[31:8] == $past(opc[31:8]))); // R7
  AST_POSTMIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (in_valid && post == 3'd5 && !dst_sg |=> out_result <= $past(opc))); // R9
  AST_POSTMAX_BOUND: assert property (@(posedge clk) disable iff (rst)
    (in_valid && post == 3'd6 && !dst_sg |=> out_result >= $past(opc))); // R9
  AST_CLAMP_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat && post == 3'd7 && (dst_sg != res_sg) |=> !out_result[31])); // R6

endmodule

// File: tb/tb_vid_minmax_unit.sv
`timescale 1ns/1ps
module tb_vid_minmax_unit;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [63:0] insn = '0;
  logic [31:0] opa = 0, opb = 0, opc = 0;
  logic out_valid;
  logic [31:0] out_result;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  vid_minmax_unit dut (.clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .opa(opa),
                       .opb(opb), .opc(opc), .out_valid(out_valid), .out_result(out_result));

  function automatic logic [63:0] mk(bit [2:0] af, bit as, bit [2:0] bf, bit breg, bit bs,
                                     bit [19:0] imm, bit mx, bit sat, bit ds, bit [2:0] post);
    logic [63:0] w = '0;
    w[35:16] = imm;
    if (breg) w[30:28] = bf;
    w[38:36] = af; w[48] = as; w[49] = bs; w[50] = breg;
    w[56] = mx; w[55] = sat; w[54] = ds; w[53:51] = post;
    return w;
  endfunction

  function automatic longint lane_val(bit [31:0] r, bit [1:0] tc, bit [1:0] sel, bit sg);
    int w, s;
    longint v;
    w = (tc == 2'd3) ? 32 : (tc == 2'd2) ? 16 : 8;
    s = (tc == 2'd3) ? 0 : (tc == 2'd2) ? int'(sel[0]) : int'(sel);
    v = longint'(r >> (s * w));
    v = v & ((64'sd1 << w) - 1);
    if (sg && v[w-1]) v = v - (64'sd1 << w);
    return v;
  endfunction

  function automatic bit [31:0] model(bit [63:0] i, bit [31:0] a, bit [31:0] b, bit [31:0] c);
    longint va, vb, v, rc, cc;
    bit rs, ds;
    bit [31:0] r;
    va = lane_val(a, i[38:37], i[37:36], i[48]);
    if (i[50]) vb = lane_val(b, i[30:29], i[29:28], i[49]);
    else begin
      vb = longint'(i[35:16]);
      if (i[49] && i[35]) vb = vb - (64'sd1 << 20);
    end
    v  = i[56] ? ((va >= vb) ? va : vb) : ((va <= vb) ? va : vb);
    rs = (i[48] == i[49]) ? i[48] : !i[56];
    ds = i[54];
    if (i[55] && ds && !rs && v > 64'sh7FFFFFFF) v = 64'sh7FFFFFFF;
    if (i[55] && !ds && rs && v < 0) v = 0;
    r  = v[31:0];
    rc = ds ? longint'($signed(r)) : longint'(r);
    cc = ds ? longint'($signed(c)) : longint'(c);
    case (i[53:51])
      3'd0: return {r[15:0], c[15:0]};
      3'd1: return {c[31:16], r[15:0]};
      3'd2: return {c[31:8], r[7:0]};
      3'd3: return {c[31:24], r[7:0], c[15:0]};
      3'd4: return r + c;
      3'd5: return (rc < cc) ? r : c;
      3'd6: return (rc > cc) ? r : c;
      default: return r;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [63:0] i, logic [31:0] a, logic [31:0] b,
                     logic [31:0] c, logic [31:0] exp);
    insn = i; opa = a; opb = b; opc = c; in_valid = 1;
    @(negedge clk);
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check(tag, out_result, exp);
    in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11 reset valid", {31'b0, out_valid}, 32'd0);
    rst = 0;
    @(negedge clk);
    check("R11 idle valid", {31'b0, out_valid}, 32'd0);

    run("R1 R2 byte lane 2", mk(3'b010,0,3'b000,1,0,0,1,0,0,3'd7), 32'h00AB0000, 32'h5, 0, 32'h000000AB);
    run("R5 signed byte3 min", mk(3'b011,1,3'b000,1,0,0,0,0,0,3'd7), 32'h80000000, 32'h5, 0, 32'hFFFFFF80);
    run("R2 halfword sel lsb", mk(3'b101,0,3'b000,1,0,0,1,0,0,3'd7), 32'h80001234, 32'h0, 0, 32'h00008000);
    run("R5 mixed max", mk(3'b111,0,3'b111,1,1,0,1,0,0,3'd7), 32'hFFFFFFFF, 32'h1, 0, 32'hFFFFFFFF);
    run("R5 mixed min", mk(3'b111,0,3'b111,1,1,0,0,0,0,3'd7), 32'hFFFFFFFF, 32'h1, 0, 32'h00000001);
    run("R3 signed imm max", mk(3'b000,0,3'b000,0,1,20'hFFFFF,1,0,0,3'd7), 32'h0, 32'h77, 0, 32'h0);
    run("R3 signed imm min", mk(3'b000,0,3'b000,0,1,20'hFFFFF,0,0,0,3'd7), 32'h0, 32'h77, 0, 32'hFFFFFFFF);
    run("R3 unsigned imm", mk(3'b110,0,3'b000,0,0,20'h80000,1,0,0,3'd7), 32'h5, 32'h0, 0, 32'h00080000);
    run("R6 clamp to max", mk(3'b110,0,3'b110,1,0,0,1,1,1,3'd7), 32'hF0000000, 32'h1, 0, 32'h7FFFFFFF);
    run("R4 no clamp", mk(3'b110,0,3'b110,1,0,0,1,0,1,3'd7), 32'hF0000000, 32'h1, 0, 32'hF0000000);
    run("R6 clamp to zero", mk(3'b000,1,3'b000,1,1,0,0,1,0,3'd7), 32'hFB, 32'h3, 0, 32'h0);
    run("R4 signed min", mk(3'b000,1,3'b000,1,1,0,0,0,0,3'd7), 32'hFB, 32'h3, 0, 32'hFFFFFFFB);
    run("R7 merge hi16", mk(3'b010,0,3'b000,1,0,0,1,0,0,3'd0), 32'h00AB0000, 32'h5, 32'h11223344, 32'h00AB3344);
    run("R7 merge lo16", mk(3'b010,0,3'b000,1,0,0,1,0,0,3'd1), 32'h00AB0000, 32'h5, 32'h11223344, 32'h112200AB);
    run("R7 merge b0", mk(3'b010,0,3'b000,1,0,0,1,0,0,3'd2), 32'h00AB0000, 32'h5, 32'h11223344, 32'h112233AB);
    run("R7 merge b2", mk(3'b010,0,3'b000,1,0,0,1,0,0,3'd3), 32'h00AB0000, 32'h5, 32'h11223344, 32'h11AB3344);
    run("R8 acc wrap", mk(3'b111,0,3'b111,1,1,0,1,0,0,3'd4), 32'hFFFFFFFF, 32'h1, 32'h2, 32'h00000001);
    run("R9 post min unsigned", mk(3'b011,1,3'b000,1,0,0,0,0,0,3'd5), 32'h80000000, 32'h5, 32'h5, 32'h00000005);
    run("R9 post min signed", mk(3'b011,1,3'b000,1,0,0,0,0,1,3'd5), 32'h80000000, 32'h5, 32'h5, 32'hFFFFFF80);
    run("R9 post max signed", mk(3'b011,1,3'b000,1,0,0,0,0,1,3'd6), 32'h80000000, 32'h5, 32'h5, 32'h00000005);
    run("R10 pass", mk(3'b000,0,3'b000,1,0,0,1,0,0,3'd7), 32'h12, 32'h34, 32'hFFFF, 32'h00000034);

    held = out_result;
    insn = ~insn; opa = ~opa; opb = ~opb; opc = ~opc;
    @(negedge clk);
    check("R11 no valid", {31'b0, out_valid}, 32'd0);
    check("R11 result holds", out_result, held);

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] ri;
      logic [31:0] ra, rb, rc;
      string tag;
      ri = {$urandom, $urandom};
      ra = $urandom; rb = $urandom; rc = $urandom;
      if (n % 4 == 0) ra = {ra[31], 31'h0};
      if (n % 5 == 0) rc = rb;
      case (ri[53:51])
        3'd0, 3'd1, 3'd2, 3'd3: tag = "R7 random";
        3'd4: tag = "R8 random";
        3'd5, 3'd6: tag = "R9 random";
        default: tag = "R10 R4 random";
      endcase
      run(tag, ri, ra, rb, rc, model(ri, ra, rb, rc));
    end

    rst = 1;
    @(negedge clk);
    check("R11 reset clears", {31'b0, out_valid}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule